// File: doc/BRIEF.md
# Debug Access Authorization Controller

This block decides whether an external debug agent may put the core into debug mode, and which classes of internal assets that agent may then reach. A debug-entry request is judged against the core's current privilege level and a per-privilege debug-enable flag. Once debug mode is active, two further conditions apply before anything is exposed: the external password checker must report a pass, and a shield bit must be clear. Only then is the effective privilege raised to machine level and are asset grants issued.

The shield bit comes out of reset set, so nothing is reachable from power-up or while boot ROM runs. Software may write it only once the boot stage has moved past ROM. Each asset carries a required access level. A grant is issued only when that level fits under both the level authorized at entry and the ceiling allowed by the current boot stage. Full access is open only in early boot. Runtime lowers the ceiling so that data left by an earlier session cannot be read.

Top module: `dbg_gate`

## Requirements
- R1: While reset is applied, and in the first cycle after it, the shield bit reads 1, the debug-mode flag is 0 and every asset grant is 0.
- R2: A write to the shield bit takes effect at the next clock edge only when the boot stage is 1 (early boot) or 2 (runtime). With stage 0 (ROM) or the unused code 3, the write is ignored and the shield bit keeps its value.
- R3: A debug request made while the privilege input is 3 (machine) sets the debug-mode flag at the next edge only when the machine debug-enable flag is 1 and the shield bit is 0.
- R4: A debug request made while the privilege input is 0 (user) sets the debug-mode flag only when the user debug-enable flag is 1 and the shield bit is 0. Requests made at privilege codes 1 and 2 are always rejected.
- R5: The effective privilege output is 3 exactly when the debug-mode flag is 1 and the password input is 1. Otherwise it equals the privilege input, in the same cycle.
- R6: Every asset grant is 0 in any cycle in which the shield bit is 1, the password input is 0, or the debug-mode flag is 0. A privileged request with a failing password never raises the effective privilege or any grant.
- R7: The authorized level is 3 when debug was entered from machine mode and 1 when it was entered from user mode. The stage ceiling is 3 in early boot, 2 in runtime, and 0 in ROM or for code 3. Asset i (level field bits [2i+1:2i] of the asset-level parameter, default levels 1,1,2,3 for assets 0..3) is granted only when the smaller of the authorized level and the ceiling is nonzero and is at least the asset's level.
- R8: An exit pulse clears the debug-mode flag at the next edge. A shield write of 1 that takes effect clears the debug-mode flag at the same edge, so the shield bit and the debug-mode flag are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_req_i | input | 1 | Debug-entry request |
| dbg_exit_i | input | 1 | Debug-exit pulse |
| priv_lvl_i | input | 2 | Current core privilege (0 user, 1 supervisor, 3 machine) |
| dbg_en_m_i | input | 1 | Debug allowed from machine mode |
| dbg_en_u_i | input | 1 | Debug allowed from user mode |
| pwd_ok_i | input | 1 | Password check passed |
| boot_stage_i | input | 2 | 0 ROM, 1 early boot, 2 runtime, 3 unused |
| reg_wr_i | input | 1 | Shield register write strobe |
| reg_wdata_i | input | 1 | Shield value to write |
| shield_o | output | 1 | Shield register readback |
| debug_mode_o | output | 1 | Debug mode active |
| eff_priv_o | output | 2 | Effective privilege level |
| asset_grant_o | output | NUM_ASSETS | Per-asset access grant |

## Verification
Entry is swept over every privilege code against all four combinations of the two enable flags. This separates a check that reads the wrong flag from one that accepts the unassigned privilege codes. After each accepted or rejected entry, the password input and all four boot-stage codes are swept. This separates the AND of debug and password from an OR, and exposes a stage ceiling or an authorized level that is off by one. Shield writes are tried in every stage, and a shield set is tried while a session is open, to show that ROM writes are refused and that the session is torn down at the same edge.

// File: rtl/dbg_gate_pkg.sv
// Shared encodings for the debug access controller: privilege codes,
// boot-stage codes, access levels and the stage ceiling function.
package dbg_gate_pkg;

    localparam int LVL_W = 2;

    localparam logic [1:0] PRIV_USER    = 2'd0;
    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    localparam logic [1:0] STAGE_ROM   = 2'd0;
    localparam logic [1:0] STAGE_EARLY = 2'd1;
    localparam logic [1:0] STAGE_RUN   = 2'd2;

    localparam logic [LVL_W-1:0] LVL_NONE   = 2'd0;
    localparam logic [LVL_W-1:0] LVL_BASIC  = 2'd1;
    localparam logic [LVL_W-1:0] LVL_SECURE = 2'd2;
    localparam logic [LVL_W-1:0] LVL_FULL   = 2'd3;

    // Highest asset level a boot stage allows; unknown codes allow nothing.
    function automatic logic [LVL_W-1:0] stage_ceiling(input logic [1:0] stage);
        case (stage)
            STAGE_EARLY: stage_ceiling = LVL_FULL;
            STAGE_RUN:   stage_ceiling = LVL_SECURE;
            default:     stage_ceiling = LVL_NONE;
        endcase
    endfunction

    // Software may touch the shield only once ROM has handed over.
    function automatic logic stage_allows_write(input logic [1:0] stage);
        stage_allows_write = (stage == STAGE_EARLY) || (stage == STAGE_RUN);
    endfunction

endpackage

// File: rtl/dbg_shield_reg.sv
// Shield control register. Resets to 1 (debug blocked). Accepts software
// writes only in early boot or runtime. Exposes its next-state value so
// that the entry logic can tear down a session at the same edge.
// Assumes: boot stage is stable around the write strobe.
module dbg_shield_reg
    import dbg_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wdata,
    input  logic [1:0] stage,
    output logic       shield_q,
    output logic       shield_d
);

    // Next value: take the write only when the stage permits it.
    always_comb begin
        shield_d = shield_q;
        if (wr_en && stage_allows_write(stage)) begin
            shield_d = wdata;
        end
    end

    // State register, safe (shielded) value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shield_q <= 1'b1;
        end else begin
            shield_q <= shield_d;
        end
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
// Debug-mode entry and exit control. A request is accepted from machine
// or user mode when that mode's enable flag is set and the shield stays
// clear. Records the level authorized at entry.
// Assumes: shield_next is the shield register's next-state value.
module dbg_entry_ctrl
    import dbg_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             exit_req,
    input  logic [1:0]       priv,
    input  logic             en_m,
    input  logic             en_u,
    input  logic             shield_next,
    output logic             debug_q,
    output logic [LVL_W-1:0] auth_q
);

    logic             priv_ok;
    logic             debug_d;
    logic [LVL_W-1:0] auth_d;

    // Privilege check: only machine and user codes have an enable flag.
    always_comb begin
        priv_ok = ((priv == PRIV_MACHINE) && en_m) ||
                  ((priv == PRIV_USER)    && en_u);
    end

    // Next-state: shield beats exit, exit beats entry.
    always_comb begin
        debug_d = debug_q;
        auth_d  = auth_q;
        if (shield_next || exit_req) begin
            debug_d = 1'b0;
            auth_d  = LVL_NONE;
        end else if (!debug_q && req && priv_ok) begin
            debug_d = 1'b1;
            auth_d  = (priv == PRIV_MACHINE) ? LVL_FULL : LVL_BASIC;
        end
    end

    // Session state registers, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debug_q <= 1'b0;
            auth_q  <= LVL_NONE;
        end else begin
            debug_q <= debug_d;
            auth_q  <= auth_d;
        end
    end

endmodule

// File: rtl/dbg_asset_grant.sv
// Per-asset grant logic. An asset is granted when a session is open, the
// password passed, the shield is clear, and its level fits under both the
// authorized level and the current boot-stage ceiling.
// Assumes: ASSET_LVL packs one LVL_W-bit level per asset, asset 0 lowest.
module dbg_asset_grant
    import dbg_gate_pkg::*;
#(
    parameter int                        NUM_ASSETS = 4,
    parameter logic [2*NUM_ASSETS-1:0]   ASSET_LVL  = 8'hE5
) (
    input  logic                  debug_q,
    input  logic [LVL_W-1:0]      auth_lvl,
    input  logic                  pwd_ok,
    input  logic                  shield_q,
    input  logic [1:0]            stage,
    output logic [NUM_ASSETS-1:0] grant
);

    logic [LVL_W-1:0] ceiling;
    logic [LVL_W-1:0] eff_lvl;
    logic             session_open;

    // Combine authorized level and stage ceiling into one limit.
    always_comb begin
        ceiling      = stage_ceiling(stage);
        eff_lvl      = (auth_lvl < ceiling) ? auth_lvl : ceiling;
        session_open = debug_q && pwd_ok && !shield_q && (eff_lvl != LVL_NONE);
    end

    // One comparator per asset against its fixed level.
    for (genvar i = 0; i < NUM_ASSETS; i++) begin : g_asset
        localparam logic [LVL_W-1:0] REQ_LVL = ASSET_LVL[LVL_W*i +: LVL_W];
        always_comb begin
            grant[i] = session_open && (REQ_LVL <= eff_lvl);
        end
    end

endmodule

// File: rtl/dbg_gate.sv
// Top of the debug access controller. Ties together the shield register,
// the entry control and the asset grant logic, and forms the effective
// privilege, which is raised to machine only with both an open session
// and a passing password.
module dbg_gate
    import dbg_gate_pkg::*;
#(
    parameter int                      NUM_ASSETS = 4,
    parameter logic [2*NUM_ASSETS-1:0] ASSET_LVL  = 8'hE5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dbg_req_i,
    input  logic                  dbg_exit_i,
    input  logic [1:0]            priv_lvl_i,
    input  logic                  dbg_en_m_i,
    input  logic                  dbg_en_u_i,
    input  logic                  pwd_ok_i,
    input  logic [1:0]            boot_stage_i,
    input  logic                  reg_wr_i,
    input  logic                  reg_wdata_i,
    output logic                  shield_o,
    output logic                  debug_mode_o,
    output logic [1:0]            eff_priv_o,
    output logic [NUM_ASSETS-1:0] asset_grant_o
);

    logic             shield_q;
    logic             shield_d;
    logic             debug_q;
    logic [LVL_W-1:0] auth_q;

    dbg_shield_reg u_shield (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_i),
        .wdata    (reg_wdata_i),
        .stage    (boot_stage_i),
        .shield_q (shield_q),
        .shield_d (shield_d)
    );

    dbg_entry_ctrl u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (dbg_req_i),
        .exit_req    (dbg_exit_i),
        .priv        (priv_lvl_i),
        .en_m        (dbg_en_m_i),
        .en_u        (dbg_en_u_i),
        .shield_next (shield_d),
        .debug_q     (debug_q),
        .auth_q      (auth_q)
    );

    dbg_asset_grant #(
        .NUM_ASSETS (NUM_ASSETS),
        .ASSET_LVL  (ASSET_LVL)
    ) u_grant (
        .debug_q  (debug_q),
        .auth_lvl (auth_q),
        .pwd_ok   (pwd_ok_i),
        .shield_q (shield_q),
        .stage    (boot_stage_i),
        .grant    (asset_grant_o)
    );

    // Elevation needs both the session and the password, never just one.
    always_comb begin
        eff_priv_o = (debug_q && pwd_ok_i) ? PRIV_MACHINE : priv_lvl_i;
    end

    assign shield_o     = shield_q;
    assign debug_mode_o = debug_q;

endmodule

// File: rtl/dbg_gate_chk.sv
// Port-level checker for dbg_gate, attached with bind below.
module dbg_gate_chk #(
    parameter int NUM_ASSETS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dbg_req_i,
    input logic [1:0]            priv_lvl_i,
    input logic                  dbg_en_m_i,
    input logic                  dbg_en_u_i,
    input logic                  pwd_ok_i,
    input logic [1:0]            boot_stage_i,
    input logic                  shield_o,
    input logic                  debug_mode_o,
    input logic [1:0]            eff_priv_o,
    input logic [NUM_ASSETS-1:0] asset_grant_o
);

    p_reset_safe_r1: assert property (@(posedge clk)
        !rst_n |=> (shield_o && !debug_mode_o));

    p_rom_write_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((boot_stage_i == 2'd0) || (boot_stage_i == 2'd3)) |=> $stable(shield_o));

    p_entry_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debug_mode_o) |-> $past(dbg_req_i && !shield_o &&
            (((priv_lvl_i == 2'd3) && dbg_en_m_i) || ((priv_lvl_i == 2'd0) && dbg_en_u_i))));

    p_no_entry_mid_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!debug_mode_o && ((priv_lvl_i == 2'd1) || (priv_lvl_i == 2'd2))) |=> !debug_mode_o);

    p_elevate_needs_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!debug_mode_o || !pwd_ok_i) |-> (eff_priv_o == priv_lvl_i));

    p_grant_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shield_o || !pwd_ok_i || !debug_mode_o) |-> (asset_grant_o == '0));

    p_rom_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((boot_stage_i == 2'd0) || (boot_stage_i == 2'd3)) |-> (asset_grant_o == '0));

    p_shield_excludes_debug_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shield_o |-> !debug_mode_o);

endmodule

bind dbg_gate dbg_gate_chk #(.NUM_ASSETS(NUM_ASSETS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_req_i     (dbg_req_i),
    .priv_lvl_i    (priv_lvl_i),
    .dbg_en_m_i    (dbg_en_m_i),
    .dbg_en_u_i    (dbg_en_u_i),
    .pwd_ok_i      (pwd_ok_i),
    .boot_stage_i  (boot_stage_i),
    .shield_o      (shield_o),
    .debug_mode_o  (debug_mode_o),
    .eff_priv_o    (eff_priv_o),
    .asset_grant_o (asset_grant_o)
);

// File: tb/dbg_gate_tb_top.sv
// Self-checking bench: sweeps entry conditions, password and boot stage.
module dbg_gate_tb_top;

    localparam int         NA   = 4;
    localparam logic [7:0] LVLS = 8'hE5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbg_req_i = 1'b0;
    logic          dbg_exit_i = 1'b0;
    logic [1:0]    priv_lvl_i = 2'd0;
    logic          dbg_en_m_i = 1'b0;
    logic          dbg_en_u_i = 1'b0;
    logic          pwd_ok_i = 1'b0;
    logic [1:0]    boot_stage_i = 2'd0;
    logic          reg_wr_i = 1'b0;
    logic          reg_wdata_i = 1'b0;
    logic          shield_o;
    logic          debug_mode_o;
    logic [1:0]    eff_priv_o;
    logic [NA-1:0] asset_grant_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    dbg_gate #(.NUM_ASSETS(NA), .ASSET_LVL(LVLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_req_i(dbg_req_i), .dbg_exit_i(dbg_exit_i),
        .priv_lvl_i(priv_lvl_i), .dbg_en_m_i(dbg_en_m_i), .dbg_en_u_i(dbg_en_u_i),
        .pwd_ok_i(pwd_ok_i), .boot_stage_i(boot_stage_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .shield_o(shield_o), .debug_mode_o(debug_mode_o),
        .eff_priv_o(eff_priv_o), .asset_grant_o(asset_grant_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_shield(input logic v, input logic [1:0] stg);
        @(negedge clk);
        boot_stage_i = stg; reg_wr_i = 1'b1; reg_wdata_i = v;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic pulse_exit();
        @(negedge clk);
        dbg_exit_i = 1'b1;
        @(negedge clk);
        dbg_exit_i = 1'b0;
    endtask

    // Expected grants from the level rules of R7.
    function automatic logic [NA-1:0] exp_grant(input bit acc, input logic [1:0] pr,
                                                 input bit pw, input logic [1:0] stg);
        int cap, auth, lim;
        logic [NA-1:0] g;
        cap  = (stg == 2'd1) ? 3 : (stg == 2'd2) ? 2 : 0;
        auth = (pr == 2'd3) ? 3 : 1;
        lim  = (auth < cap) ? auth : cap;
        for (int i = 0; i < NA; i++) begin
            g[i] = acc && pw && (lim != 0) && (int'(LVLS[2*i +: 2]) <= lim);
        end
        return g;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 shield in reset", shield_o, 1);
        chk("R1 debug in reset", debug_mode_o, 0);
        chk("R1 grants in reset", asset_grant_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 shield after reset", shield_o, 1);

        // R2: shield write accepted only in stages 1 and 2.
        for (int s = 0; s < 4; s++) begin
            write_shield(1'b0, 2'(s));
            chk($sformatf("R2 clear in stage %0d", s), shield_o, (s == 1 || s == 2) ? 0 : 1);
            write_shield(1'b1, 2'd1);
            chk("R2 set back", shield_o, 1);
        end

        // R3: shielded request refused even when enabled.
        @(negedge clk);
        priv_lvl_i = 2'd3; dbg_en_m_i = 1'b1; dbg_req_i = 1'b1;
        @(negedge clk);
        dbg_req_i = 1'b0;
        chk("R3 shielded request", debug_mode_o, 0);

        write_shield(1'b0, 2'd2);
        chk("R2 runtime clear", shield_o, 0);

        // Full sweep of entry conditions, password and stage.
        for (int pr = 0; pr < 4; pr++) begin
            for (int em = 0; em < 2; em++) begin
                for (int eu = 0; eu < 2; eu++) begin
                    bit acc;
                    acc = (pr == 3 && em == 1) || (pr == 0 && eu == 1);
                    pulse_exit();
                    @(negedge clk);
                    priv_lvl_i = 2'(pr); dbg_en_m_i = em[0]; dbg_en_u_i = eu[0];
                    pwd_ok_i = 1'b0; boot_stage_i = 2'd2; dbg_req_i = 1'b1;
                    @(negedge clk);
                    dbg_req_i = 1'b0;
                    chk($sformatf("%s entry pr=%0d em=%0d eu=%0d", (pr == 3) ? "R3" : "R4",
                        pr, em, eu), debug_mode_o, acc);
                    for (int pw = 0; pw < 2; pw++) begin
                        for (int s = 0; s < 4; s++) begin
                            pwd_ok_i = pw[0]; boot_stage_i = 2'(s);
                            #1;
                            chk($sformatf("R5 eff priv pr=%0d pw=%0d", pr, pw), eff_priv_o,
                                (acc && pw == 1) ? 3 : pr);
                            if (pw == 0)
                                chk("R6 grants with failing password", asset_grant_o, 0);
                            else
                                chk($sformatf("R7 grants pr=%0d stage=%0d", pr, s),
                                    asset_grant_o, exp_grant(acc, 2'(pr), 1'b1, 2'(s)));
                        end
                    end
                    pwd_ok_i = 1'b0;
                    pulse_exit();
                    chk("R8 exit clears debug", debug_mode_o, 0);
                end
            end
        end

        // R8/R6: shield set tears the session down at the same edge.
        @(negedge clk);
        priv_lvl_i = 2'd3; dbg_en_m_i = 1'b1; boot_stage_i = 2'd1; dbg_req_i = 1'b1;
        @(negedge clk);
        dbg_req_i = 1'b0; pwd_ok_i = 1'b1;
        #1;
        chk("R7 machine early boot full grant", asset_grant_o, 4'b1111);
        write_shield(1'b1, 2'd1);
        chk("R8 shield set", shield_o, 1);
        chk("R8 shield clears debug", debug_mode_o, 0);
        chk("R6 shield clears grants", asset_grant_o, 0);
        chk("R5 no elevation under shield", eff_priv_o, 3);
        priv_lvl_i = 2'd0;
        #1;
        chk("R5 follows input under shield", eff_priv_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule